// File: doc/BRIEF.md
# Register-Driven SPI Word Engine

This block is an SPI master controlled entirely through a five-entry register file. Software sets a serial clock divider and enable, sets clock polarity, clock phase and chip-select polarity for each of four chip selects, then issues one command per word. Each accepted command moves exactly one word of up to 32 bits, either out on the data line or in from the slave. Software polls the status register until the word is done.

Chip select is asserted at the first word of a frame and stays asserted across words. The frame ends in one of three ways: an invalidate command, the completion of the word count named in the command, or a word addressed to a different chip select. A 3-pin option lets one shared data line carry both directions. The block drives that line during writes and releases it during reads.

Register word addresses are: 0 clock control, 1 device control, 2 command, 3 status (read only), 4 data.

Top module: `spi_word_engine`

## Requirements
- R1: Clock control has the enable at bit 31 and the divider at bits 15:0. One bit period lasts divider+1 functional clock cycles, and a divider of 0 is treated as 1, so a word of L bits keeps busy high for exactly L*(max(divider,1)+1) cycles.
- R2: While the enable is 0, an accepted word does not advance and SCLK stays at its idle level. Setting the enable lets the word finish normally.
- R3: The command register holds the chip select at bits 29:28, the 3-pin select at bit 27, the word length minus one at bits 25:19, the operation at bits 18:16 and the frame length at bits 11:0. Operation 1 is a read, 2 is a write and 4 is an invalidate. Any other operation code changes neither status nor chip selects.
- R4: A write shifts the low L bits of the data register out on dq0_o, most significant bit first.
- R5: A read shifts in L bits, most significant first, and places them right-aligned in the data register when the word completes.
- R6: Status bit 0 is busy and bit 1 is word-complete. An accepted read or write clears word-complete and sets busy. The end of the last bit clears busy and sets word-complete.
- R7: Device control gives chip select n the byte at bits 8n+7:8n. Bit 0 of that byte is clock polarity (SCLK idle level), bit 1 is chip-select polarity (1 = active high) and bit 2 is clock phase (1 = sample on the trailing edge).
- R8: Chip select asserts when a word starts and stays asserted between words of a frame. An invalidate command deasserts it. A word for a different chip select moves the assertion to that chip select.
- R9: With a nonzero frame length F, chip select deasserts by itself as the F-th word of the frame completes.
- R10: In 3-pin mode a read takes its data from dq0_i and holds dq0_oe low while the word runs. A 3-pin write keeps dq0_oe high.
- R11: A command written while busy is ignored. The running word, the chip selects and the stored command are unaffected.
- R12: A word length field above 31 is clamped to a 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 4 | Chip-select pins, polarity per device control |
| dq0_o | output | 1 | Serial data out / shared line output |
| dq0_oe | output | 1 | Output enable for the dq0 pad |
| dq0_i | input | 1 | Shared line input (3-pin mode) |
| dq1_i | input | 1 | Serial data in (4-pin mode) |

## Verification
The assertions assume that software changes the divider only while the enable is low. They also assume that device control is not rewritten while a word is running and that the chip-select field never names a select above three. The bench writes the divider and device control only while status shows idle. It switches the enable mid-word only in the stall scenario, which the engine handles by freezing. A bench slave model follows each sclk sampling edge for the programmed polarity and phase, so both the transmitted and the received bit streams are checked at the pins.

// File: rtl/spi_we_pkg.sv
package spi_we_pkg;

  localparam logic [2:0] ADDR_CLK  = 3'd0;
  localparam logic [2:0] ADDR_DEV  = 3'd1;
  localparam logic [2:0] ADDR_CMD  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_DATA = 3'd4;

  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_WR  = 3'd2;
  localparam logic [2:0] OP_INV = 3'd4;

  localparam int CLK_EN_BIT = 31;
  localparam int CMD_CS_LSB = 28;
  localparam int CMD_3P_BIT = 27;
  localparam int CMD_WL_LSB = 19;
  localparam int CMD_OP_LSB = 16;

  typedef struct packed {
    logic [1:0]  cs;
    logic        three;
    logic [6:0]  wlen;
    logic [2:0]  op;
    logic [11:0] flen;
  } cmd_t;

endpackage

// File: rtl/spi_we_clkgen.sv
module spi_we_clkgen #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic            cpha,
  input  logic [DIVW-1:0] div,
  output logic            sample_o,
  output logic            bit_end_o,
  output logic            sclk_act_o
);

  logic [DIVW-1:0] cnt_q, cnt_d;
  logic [DIVW-1:0] lim, half;
  logic [DIVW:0]   lim_p1;

  always_comb begin
    lim    = (div == '0) ? DIVW'(1) : div;
    lim_p1 = {1'b0, lim} + 1'b1;
    half   = lim_p1[DIVW:1];
  end

  assign sample_o   = run && (cnt_q == half - 1'b1);
  assign bit_end_o  = run && (cnt_q == lim);
  assign sclk_act_o = cpha ? (cnt_q < half) : (cnt_q >= half);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)        cnt_d = '0;
    else if (bit_end_o) cnt_d = '0;
    else if (run)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));

  // R1
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |=> (cnt_q == '0));

endmodule

// File: rtl/spi_we_shifter.sv
module spi_we_shifter #(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_read,
  input  logic          go_three,
  input  logic [LW-1:0] go_len,
  input  logic [DW-1:0] go_data,
  input  logic          sample,
  input  logic          bit_end,
  input  logic          din,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_read_o,
  output logic [DW-1:0] rx_o,
  output logic          dout_o,
  output logic          doe_o
);

  logic          busy_q, busy_d;
  logic          rd_q, rd_d;
  logic          three_q, three_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          last_bit;

  assign last_bit  = (idx_q == len_q - 1'b1);
  assign done_o    = busy_q && bit_end && last_bit;
  assign busy_o    = busy_q;
  assign is_read_o = rd_q;
  assign rx_o      = rx_q;
  assign dout_o    = tx_q[DW-1];
  assign doe_o     = !(busy_q && three_q && rd_q);

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    three_d = three_q;
    len_d   = len_q;
    idx_d   = idx_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    if (go && !busy_q) begin
      busy_d  = 1'b1;
      rd_d    = go_read;
      three_d = go_three;
      len_d   = go_len;
      idx_d   = '0;
      rx_d    = '0;
      tx_d    = go_read ? '0 : (go_data << (LW'(DW) - go_len));
    end else if (busy_q) begin
      if (sample) rx_d = {rx_q[DW-2:0], din};
      if (bit_end) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          tx_d  = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      three_q <= 1'b0;
      len_q   <= LW'(1);
      idx_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      three_q <= three_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy_q) |=> busy_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);

  // R12
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (len_q != '0 && len_q <= LW'(DW) && idx_q < len_q));

endmodule

// File: rtl/spi_we_csctl.sv
module spi_we_csctl #(
  parameter int NCS = 4,
  parameter int CSW = 2,
  parameter int FLW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [CSW-1:0] go_cs,
  input  logic           inv,
  input  logic           word_done,
  input  logic [FLW-1:0] flen,
  output logic [NCS-1:0] act_o
);

  logic           active_q, active_d;
  logic [CSW-1:0] sel_q, sel_d;
  logic [FLW-1:0] cnt_q, cnt_d;
  logic [FLW:0]   cnt_inc;
  logic           frame_full;

  assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
  assign frame_full = (flen != '0) && (cnt_inc >= {1'b0, flen});

  always_comb begin
    active_d = active_q;
    sel_d    = sel_q;
    cnt_d    = cnt_q;
    if (inv) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (go) begin
      if (!active_q || sel_q != go_cs) begin
        active_d = 1'b1;
        sel_d    = go_cs;
        cnt_d    = '0;
      end
    end else if (word_done && active_q) begin
      if (frame_full) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_inc[FLW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      sel_q    <= sel_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar n = 0; n < NCS; n++) begin : g_act
    assign act_o[n] = active_q && (sel_q == CSW'(n));
  end

  // R8
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_o));

  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && active_q && !inv && !go && frame_full) |=> !active_q);

  // R8
  inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> (act_o == '0));

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_we_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCS  = 4,
  parameter int DIVW = 16,
  parameter int FLW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_o,
  output logic           dq0_o,
  output logic           dq0_oe,
  input  logic           dq0_i,
  input  logic           dq1_i
);

  localparam int LW  = $clog2(DW) + 1;
  localparam int CSW = 2;
  localparam int DCW = NCS * 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register state
  logic            en_q, en_d;
  logic [DIVW-1:0] div_q, div_d;
  logic [DCW-1:0]  dev_q, dev_d;
  cmd_t            cmd_q, cmd_d;
  logic [DW-1:0]   data_q, data_d;
  logic            wc_q, wc_d;

  // decode
  logic          clk_we, dev_we, cmd_wr, data_we;
  logic [2:0]    wop;
  logic          busy, done, is_read;
  logic          word_go, inv_go;
  logic [7:0]    len_full;
  logic [LW-1:0] go_len;
  logic [7:0]    cur_fld;
  logic          cur_cpol, cur_cpha;
  logic [DW-1:0] rx_word;
  logic          sample, bit_end, sclk_act, run, din;
  logic [NCS-1:0] cs_act;
  logic          sh_dout, sh_doe;

  assign clk_we  = bus_wr && (bus_addr == ADDR_CLK);
  assign dev_we  = bus_wr && (bus_addr == ADDR_DEV);
  assign cmd_wr  = bus_wr && (bus_addr == ADDR_CMD);
  assign data_we = bus_wr && (bus_addr == ADDR_DATA);
  assign wop     = bus_wdata[CMD_OP_LSB +: 3];
  assign word_go = cmd_wr && !busy && (wop == OP_RD || wop == OP_WR);
  assign inv_go  = cmd_wr && !busy && (wop == OP_INV);

  always_comb begin
    len_full = {1'b0, bus_wdata[CMD_WL_LSB +: 7]} + 8'd1;
    go_len   = (len_full > 8'(DW)) ? LW'(DW) : LW'(len_full);
  end

  always_comb begin
    cur_fld = '0;
    for (int i = 0; i < NCS; i++) begin
      if (cmd_q.cs == CSW'(i)) cur_fld = dev_q[i*8 +: 8];
    end
    cur_cpol = cur_fld[0];
    cur_cpha = cur_fld[2];
  end

  // next-state
  always_comb begin
    en_d   = en_q;
    div_d  = div_q;
    dev_d  = dev_q;
    cmd_d  = cmd_q;
    data_d = data_q;
    wc_d   = wc_q;
    if (clk_we) begin
      en_d  = bus_wdata[CLK_EN_BIT];
      div_d = bus_wdata[DIVW-1:0];
    end
    if (dev_we) dev_d = bus_wdata[DCW-1:0];
    if (word_go || inv_go) begin
      cmd_d.cs    = bus_wdata[CMD_CS_LSB +: CSW];
      cmd_d.three = bus_wdata[CMD_3P_BIT];
      cmd_d.wlen  = bus_wdata[CMD_WL_LSB +: 7];
      cmd_d.op    = wop;
      cmd_d.flen  = bus_wdata[FLW-1:0];
    end
    if (done && is_read)  data_d = rx_word;
    else if (data_we)     data_d = bus_wdata[DW-1:0];
    if (word_go)          wc_d = 1'b0;
    else if (done)        wc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      dev_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
      wc_q   <= 1'b0;
    end else begin
      if (clk_we)                   en_q   <= en_d;
      if (clk_we)                   div_q  <= div_d;
      if (dev_we)                   dev_q  <= dev_d;
      if (word_go || inv_go)        cmd_q  <= cmd_d;
      if (data_we || done)          data_q <= data_d;
      if (word_go || done)          wc_q   <= wc_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CLK: begin
        bus_rdata[CLK_EN_BIT] = en_q;
        bus_rdata[DIVW-1:0]   = div_q;
      end
      ADDR_DEV:  bus_rdata[DCW-1:0] = dev_q;
      ADDR_CMD: begin
        bus_rdata[CMD_CS_LSB +: CSW] = cmd_q.cs;
        bus_rdata[CMD_3P_BIT]        = cmd_q.three;
        bus_rdata[CMD_WL_LSB +: 7]   = cmd_q.wlen;
        bus_rdata[CMD_OP_LSB +: 3]   = cmd_q.op;
        bus_rdata[FLW-1:0]           = cmd_q.flen;
      end
      ADDR_STAT: bus_rdata[1:0] = {wc_q, busy};
      ADDR_DATA: bus_rdata[DW-1:0] = data_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign run = busy && en_q;
  assign din = cmd_q.three ? dq0_i : dq1_i;

  spi_we_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_ni),
    .restart   (word_go),
    .run       (run),
    .cpha      (cur_cpha),
    .div       (div_q),
    .sample_o  (sample),
    .bit_end_o (bit_end),
    .sclk_act_o(sclk_act)
  );

  spi_we_shifter #(.DW(DW), .LW(LW)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (word_go),
    .go_read  (wop == OP_RD),
    .go_three (bus_wdata[CMD_3P_BIT]),
    .go_len   (go_len),
    .go_data  (data_q),
    .sample   (sample),
    .bit_end  (bit_end),
    .din      (din),
    .busy_o   (busy),
    .done_o   (done),
    .is_read_o(is_read),
    .rx_o     (rx_word),
    .dout_o   (sh_dout),
    .doe_o    (sh_doe)
  );

  spi_we_csctl #(.NCS(NCS), .CSW(CSW), .FLW(FLW)) u_csctl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (word_go),
    .go_cs    (bus_wdata[CMD_CS_LSB +: CSW]),
    .inv      (inv_go),
    .word_done(done),
    .flen     (cmd_q.flen),
    .act_o    (cs_act)
  );

  assign sclk_o = cur_cpol ^ (run && sclk_act);
  assign dq0_o  = sh_dout;
  assign dq0_oe = sh_doe;

  for (genvar n = 0; n < NCS; n++) begin : g_cs
    assign cs_o[n] = cs_act[n] ? dev_q[n*8 + 1] : ~dev_q[n*8 + 1];
  end

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && cmd_wr) |=> ($stable(cmd_q) && $stable(cs_act)));

  // R10
  tri_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && cmd_q.three && cmd_q.op == OP_RD) |-> !dq0_oe);

  // R6
  wc_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    word_go |=> (!wc_q && busy));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_q && $past(!en_q) && $stable(dev_q) && $stable(cmd_q.cs)) |-> $stable(sclk_o));

endmodule

// File: tb/spi_word_engine_tb_top.sv
`timescale 1ns/1ps
module spi_word_engine_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sclk_o;
  logic [3:0]  cs_o;
  logic        dq0_o, dq0_oe, dq0_in, slv_bit;

  int n_tests = 0;
  int n_fail  = 0;

  // slave model state
  logic        b_cpol = 1'b0;
  logic        b_cpha = 1'b0;
  logic        in_word = 1'b0;
  logic [31:0] miso_word = '0;
  int          b_len = 8;
  int          base = 0;
  int          tot = 0;
  logic [31:0] cap = '0;
  int          oe_low_cnt = 0;
  logic        samp_lvl;

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] obs_val;
  event        obs_ev;

  spi_word_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .cs_o(cs_o), .dq0_o(dq0_o), .dq0_oe(dq0_oe), .dq0_i(dq0_in),
    .dq1_i(slv_bit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign samp_lvl = b_cpha ? b_cpol : ~b_cpol;
  assign dq0_in   = dq0_oe ? dq0_o : slv_bit;
  assign slv_bit  = ((tot - base) < b_len && (tot - base) >= 0) ?
                    miso_word[b_len - 1 - (tot - base)] : 1'b0;

  always @(sclk_o) begin
    if (in_word && sclk_o == samp_lvl) begin
      cap = {cap[30:0], dq0_o};
      #1 tot = tot + 1;
    end
  end

  always @(negedge clk) if (in_word && !dq0_oe) oe_low_cnt = oe_low_cnt + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(obs_ev);
      chk(tag_q.pop_front(), obs_val, exp_q.pop_front());
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] s;
    n = 0;
    forever begin
      rd(3'd3, s);
      if (!s[0] || n > 50000) break;
      n++;
    end
  endtask

  function automatic logic [31:0] mkcmd(int cs, int len, bit three, int op, int flen);
    return (32'(cs) << 28) | (32'(three) << 27) | (32'(len - 1) << 19) |
           (32'(op) << 16) | 32'(flen);
  endfunction

  function automatic logic [31:0] lmask(int eff);
    return (eff >= 32) ? 32'hFFFF_FFFF : ((32'h1 << eff) - 1);
  endfunction

  // drives one word, pushes the expectation, posts the observation
  task automatic do_word(string tag, int cs, int len, bit three, int op, int flen,
                         logic [31:0] txd, logic [31:0] mw, int exp_cyc);
    int eff;
    int cyc;
    logic [31:0] v;
    eff = (len > 32) ? 32 : len;
    if (op == 2) wr(3'd4, txd);
    miso_word = mw; b_len = eff; base = tot; in_word = 1'b1;
    exp_q.push_back((op == 2 ? txd : mw) & lmask(eff));
    tag_q.push_back(tag);
    wr(3'd2, mkcmd(cs, len, three, op, flen));
    wait_done(cyc);
    in_word = 1'b0;
    if (op == 2) obs_val = cap & lmask(eff);
    else begin rd(3'd4, v); obs_val = v; end
    -> obs_ev;
    #1;
    if (exp_cyc > 0) chk({tag, " R1 busy cycles"}, 32'(cyc), 32'(exp_cyc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    int bad;
    int oe0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state
    rd(3'd3, v); chk("R6 reset status", v, 32'h0);
    chk("R8 reset cs", 32'(cs_o), 32'hF);
    chk("R7 reset sclk", 32'(sclk_o), 32'h0);
    rd(3'd4, v); chk("R5 reset data", v, 32'h0);

    wr(3'd0, 32'h8000_0003);
    wr(3'd1, 32'h0);

    // R4 write, frame of two words on cs0
    do_word("R4 write", 0, 8, 0, 2, 2, 32'hA5, 32'h0, 32);
    rd(3'd3, v); chk("R6 status done", v, 32'h2);
    chk("R8 cs held in frame", 32'(cs_o), 32'hE);
    // R5 read, completes the frame
    do_word("R5 read", 0, 8, 0, 1, 2, 32'h0, 32'h3C, 32);
    chk("R9 auto deassert", 32'(cs_o), 32'hF);

    // R1 divider 0 treated as 1
    wr(3'd0, 32'h8000_0000);
    do_word("R1 div0 write", 0, 4, 0, 2, 1, 32'h9, 32'h0, 8);

    // R7 mode 3, active-high cs1
    wr(3'd0, 32'h8000_0003);
    wr(3'd1, 32'h0000_0700);
    b_cpol = 1'b1; b_cpha = 1'b1;
    #1 chk("R7 cs1 high polarity idle", 32'(cs_o), 32'hD);
    do_word("R7 mode3 write", 1, 16, 0, 2, 0, 32'hBEEF, 32'h0, 64);
    chk("R8 cs1 held", 32'(cs_o), 32'hF);
    chk("R7 sclk idle high", 32'(sclk_o), 32'h1);
    do_word("R7 mode3 read", 1, 12, 0, 1, 0, 32'h0, 32'hABC, 48);
    chk("R8 cs1 still held", 32'(cs_o), 32'hF);
    wr(3'd2, mkcmd(1, 8, 0, 4, 0));
    #1 chk("R8 invalidate", 32'(cs_o), 32'hD);

    // R3 unsupported op code 7
    wr(3'd2, mkcmd(2, 8, 0, 7, 0));
    rd(3'd3, v); chk("R3 op7 status", v, 32'h2);
    chk("R3 op7 cs", 32'(cs_o), 32'hD);

    wr(3'd1, 32'h0);
    b_cpol = 1'b0; b_cpha = 1'b0;

    // R11 command while busy
    wr(3'd4, 32'h5C);
    miso_word = '0; b_len = 8; base = tot; in_word = 1'b1;
    wr(3'd2, mkcmd(0, 8, 0, 2, 1));
    wr(3'd2, mkcmd(2, 8, 0, 1, 0));
    chk("R11 cs unchanged while busy", 32'(cs_o), 32'hE);
    wait_done(cyc);
    in_word = 1'b0;
    chk("R11 word intact", cap & 32'hFF, 32'h5C);
    rd(3'd2, v); chk("R11 stored cmd", v, mkcmd(0, 8, 0, 2, 1));

    // R2 enable low stalls
    wr(3'd0, 32'h0000_0003);
    wr(3'd4, 32'hC3);
    miso_word = '0; b_len = 8; base = tot; in_word = 1'b1;
    wr(3'd2, mkcmd(0, 8, 0, 2, 1));
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      rd(3'd3, v);
      if (v[0] !== 1'b1 || sclk_o !== 1'b0) bad++;
    end
    chk("R2 stall busy and idle sclk", 32'(bad), 32'h0);
    wr(3'd0, 32'h8000_0003);
    wait_done(cyc);
    in_word = 1'b0;
    chk("R2 resumed word", cap & 32'hFF, 32'hC3);

    // R10 3-pin read and write
    oe0 = oe_low_cnt;
    do_word("R10 3pin read", 0, 8, 1, 1, 1, 32'h0, 32'h5A, 32);
    chk("R10 oe low in read", 32'(oe_low_cnt > oe0), 32'h1);
    oe0 = oe_low_cnt;
    do_word("R10 3pin write", 0, 8, 1, 2, 1, 32'h33, 32'h0, 32);
    chk("R10 oe high in write", 32'(oe_low_cnt - oe0), 32'h0);

    // R12 clamp
    wr(3'd0, 32'h8000_0000);
    do_word("R12 clamp", 0, 40, 0, 2, 1, 32'hDEAD_BEEF, 32'h0, 64);

    // R8 chip-select switch
    do_word("R8 cs0 word", 0, 8, 0, 2, 0, 32'h11, 32'h0, 16);
    chk("R8 cs0 on", 32'(cs_o), 32'hE);
    do_word("R8 cs3 word", 3, 8, 0, 2, 0, 32'h22, 32'h0, 16);
    chk("R8 moved to cs3", 32'(cs_o), 32'h7);
    wr(3'd2, mkcmd(3, 8, 0, 4, 0));
    #1 chk("R8 cs3 invalidated", 32'(cs_o), 32'hF);

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule